// File: doc/BRIEF.md
# Load Data Alignment and Extension Unit

This unit sits between the data-memory read port and the register writeback stage of a 32-bit core. For each load it forms the effective address. The address is the base register value plus either a second register value or a small immediate. The immediate is scaled by the access size. The unit presents a word-aligned address to memory. From the word that memory returns, it builds the value that the destination register receives.

Byte and halfword loads pick their lane from the returned word in little-endian order. They then either zero-fill or sign-extend the upper bits. A word load at a misaligned address is not trapped. The aligned word is rotated right by eight times the two low address bits. The read data is taken as belonging to the request presented in the same cycle. The final value is captured in an output register when the request strobe is high. This register can be removed by a parameter.

Top module: `ld_align_unit`

## Requirements
- R1: With `acc_size`=00 (byte) and `offs_sel`=0 (immediate), the effective address equals `base_val` plus the 5-bit `offs_imm`, unscaled.
- R2: With `acc_size`=01 (halfword) and `offs_sel`=0, the effective address equals `base_val` plus `offs_imm`×2.
- R3: With `acc_size`=10 or 11 (word) and `offs_sel`=0, the effective address equals `base_val` plus `offs_imm`×4.
- R4: With `offs_sel`=1 (register), the effective address equals `base_val` plus `offs_reg_val` with no scaling, for every size, and `offs_imm` has no effect.
- R5: `mem_addr` equals the effective address with bits 1:0 forced to zero.
- R6: A word load returns `mem_rdata` rotated right by 8×addr[1:0]. `sign_ext` has no effect on word loads.
- R7: A byte load selects byte lane addr[1:0] of `mem_rdata` (lane 0 = bits 7:0). Bits 31:8 are zero when `sign_ext`=0 and copies of bit 7 when `sign_ext`=1.
- R8: A halfword load selects bits 15:0 when addr[1]=0 and bits 31:16 when addr[1]=1, and addr[0] is ignored. Bits 31:16 of the result are zero when `sign_ext`=0 and copies of bit 15 when `sign_ext`=1.
- R9: The converted value appears on `load_result` one clock after a cycle with `req_valid`=1. `result_valid` is `req_valid` delayed by one clock. `load_result` holds its value after a cycle with `req_valid`=0.
- R10: While `rst_n` is low, `load_result` is zero and `result_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request strobe; captures the result |
| base_val | input | 32 | Base register value |
| offs_reg_val | input | 32 | Offset register value |
| offs_imm | input | 5 | Unscaled immediate offset |
| offs_sel | input | 1 | 0 = immediate offset, 1 = register offset |
| acc_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| sign_ext | input | 1 | 1 = sign-extend byte/halfword |
| mem_addr | output | 32 | Word-aligned read address |
| mem_rdata | input | 32 | Word returned by memory |
| load_result | output | 32 | Aligned and extended register value |
| result_valid | output | 1 | Result register holds a new value |

## Verification
Directed loads walk the low address bits through all four values for each size. This separates the byte-lane choice, the halfword-lane choice (including odd addresses) and the word rotation amount. Read words with the top bit of the selected lane set and clear tell sign extension apart from zero fill. Immediate and register offset modes run with the same immediate, so a wrong scale factor or a leaked immediate shows up in the address. Random bases, offsets and data then mix all sizes and modes. Idle cycles with changed inputs show whether the result register holds.

// File: rtl/ld_align_pkg.sv
`timescale 1ns/1ps
package ld_align_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WALT = 2'b11
    } acc_size_e;

    localparam logic OFFS_IMM = 1'b0;
    localparam logic OFFS_REG = 1'b1;

endpackage

// File: rtl/ld_addr_gen.sv
`timescale 1ns/1ps
module ld_addr_gen
    import ld_align_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 5
) (
    input  logic [DATA_W-1:0] base_val,
    input  logic [DATA_W-1:0] offs_reg_val,
    input  logic [IMM_W-1:0]  offs_imm,
    input  logic              offs_sel,
    input  acc_size_e         acc_size,
    output logic [DATA_W-1:0] eff_addr,
    output logic [DATA_W-1:0] word_addr
);
    localparam int LANES = DATA_W / 8;
    localparam logic [DATA_W-1:0] ALIGN_MASK = ~DATA_W'(LANES - 1);

    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] imm_scaled;
    logic [DATA_W-1:0] offset;

    always_comb begin
        imm_ext = DATA_W'(offs_imm);
        case (acc_size)
            SZ_BYTE: imm_scaled = imm_ext;
            SZ_HALF: imm_scaled = imm_ext << 1;
            default: imm_scaled = imm_ext << 2;
        endcase
        offset    = (offs_sel == OFFS_REG) ? offs_reg_val : imm_scaled;
        eff_addr  = base_val + offset;
        word_addr = eff_addr & ALIGN_MASK;
    end
endmodule

// File: rtl/ld_lane_extract.sv
`timescale 1ns/1ps
module ld_lane_extract
    import ld_align_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]               rdata,
    input  logic [$clog2(DATA_W/8)-1:0]     lane_sel,
    input  acc_size_e                       acc_size,
    input  logic                            sign_ext,
    output logic [DATA_W-1:0]               ext_res
);
    localparam int LANES  = DATA_W / 8;
    localparam int HLANES = LANES / 2;
    localparam int SEL_W  = $clog2(LANES);
    localparam int ROT_W  = SEL_W + 3;

    logic [7:0]  byte_lane [LANES];
    logic [15:0] half_lane [HLANES];

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_bytes
            assign byte_lane[g] = rdata[8*g +: 8];
        end
        for (g = 0; g < HLANES; g++) begin : g_halves
            assign half_lane[g] = rdata[16*g +: 16];
        end
    endgenerate

    logic [ROT_W-1:0]    rot_amt;
    logic [2*DATA_W-1:0] dbl_word;
    logic [2*DATA_W-1:0] dbl_shift;
    logic [7:0]          pick_b;
    logic [15:0]         pick_h;

    always_comb begin
        rot_amt   = {lane_sel, 3'b000};
        dbl_word  = {rdata, rdata};
        dbl_shift = dbl_word >> rot_amt;
        pick_b    = byte_lane[lane_sel];
        pick_h    = half_lane[lane_sel[SEL_W-1:1]];
        case (acc_size)
            SZ_BYTE: ext_res = {{(DATA_W-8){sign_ext & pick_b[7]}}, pick_b};
            SZ_HALF: ext_res = {{(DATA_W-16){sign_ext & pick_h[15]}}, pick_h};
            default: ext_res = dbl_shift[DATA_W-1:0];
        endcase
    end
endmodule

// File: rtl/ld_align_unit.sv
`timescale 1ns/1ps
module ld_align_unit
    import ld_align_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int IMM_W   = 5,
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [DATA_W-1:0] base_val,
    input  logic [DATA_W-1:0] offs_reg_val,
    input  logic [IMM_W-1:0]  offs_imm,
    input  logic              offs_sel,
    input  logic [1:0]        acc_size,
    input  logic              sign_ext,
    output logic [DATA_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] load_result,
    output logic              result_valid
);
    localparam int LANES = DATA_W / 8;
    localparam int SEL_W = $clog2(LANES);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } out_t;

    acc_size_e         size_e;
    logic [DATA_W-1:0] eff_addr;
    logic [DATA_W-1:0] ext_res;

    assign size_e = acc_size_e'(acc_size);

    ld_addr_gen #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_addr (
        .base_val     (base_val),
        .offs_reg_val (offs_reg_val),
        .offs_imm     (offs_imm),
        .offs_sel     (offs_sel),
        .acc_size     (size_e),
        .eff_addr     (eff_addr),
        .word_addr    (mem_addr)
    );

    ld_lane_extract #(.DATA_W(DATA_W)) u_lane (
        .rdata    (mem_rdata),
        .lane_sel (eff_addr[SEL_W-1:0]),
        .acc_size (size_e),
        .sign_ext (sign_ext),
        .ext_res  (ext_res)
    );

    generate
        if (OUT_REG) begin : g_oreg
            out_t out_d, out_q;

            always_comb begin
                out_d     = out_q;
                out_d.vld = req_valid;
                if (req_valid) begin
                    out_d.data = ext_res;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    out_q <= '0;
                end else begin
                    out_q <= out_d;
                end
            end

            assign load_result  = out_q.data;
            assign result_valid = out_q.vld;
        end else begin : g_comb
            assign load_result  = ext_res;
            assign result_valid = req_valid;
        end
    endgenerate
endmodule

// File: rtl/ld_align_checker.sv
`timescale 1ns/1ps
module ld_align_checker #(
    parameter int DATA_W  = 32,
    parameter bit OUT_REG = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        acc_size,
    input logic              sign_ext,
    input logic [DATA_W-1:0] mem_addr,
    input logic [DATA_W-1:0] ext_res,
    input logic [DATA_W-1:0] load_result,
    input logic              result_valid
);
    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_addr[1:0] == 2'b00); // R5

    AST_BYTE_ZFILL: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_size == 2'b00 && !sign_ext) |-> ext_res[DATA_W-1:8] == '0); // R7

    AST_BYTE_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_size == 2'b00 && sign_ext) |-> ext_res[DATA_W-1:8] == {(DATA_W-8){ext_res[7]}}); // R7

    AST_HALF_ZFILL: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_size == 2'b01 && !sign_ext) |-> ext_res[DATA_W-1:16] == '0); // R8

    AST_HALF_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_size == 2'b01 && sign_ext) |-> ext_res[DATA_W-1:16] == {(DATA_W-16){ext_res[15]}}); // R8

    generate
        if (OUT_REG) begin : g_reg_chk
            AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> result_valid == $past(req_valid)); // R9

            AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && !$past(req_valid)) |-> $stable(load_result)); // R9

            AST_RESULT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
                req_valid |=> load_result == $past(ext_res)); // R9
        end
    endgenerate
endmodule

bind ld_align_unit ld_align_checker #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .acc_size     (acc_size),
    .sign_ext     (sign_ext),
    .mem_addr     (mem_addr),
    .ext_res      (ext_res),
    .load_result  (load_result),
    .result_valid (result_valid)
);

// File: tb/ld_align_unit_test.sv
`timescale 1ns/1ps
module ld_align_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] base_val = '0;
    logic [31:0] offs_reg_val = '0;
    logic [4:0]  offs_imm = '0;
    logic        offs_sel = 1'b0;
    logic [1:0]  acc_size = 2'b00;
    logic        sign_ext = 1'b0;
    logic [31:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic [31:0] load_result;
    logic        result_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ld_align_unit uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .base_val(base_val), .offs_reg_val(offs_reg_val), .offs_imm(offs_imm),
        .offs_sel(offs_sel), .acc_size(acc_size), .sign_ext(sign_ext),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .load_result(load_result), .result_valid(result_valid)
    );

    function automatic logic [31:0] exp_addr(logic [31:0] b, logic [31:0] r,
                                             logic [4:0] im, logic sel, logic [1:0] sz);
        logic [31:0] scale;
        if (sel) return b + r;
        scale = (sz == 2'b00) ? 32'd1 : (sz == 2'b01) ? 32'd2 : 32'd4;
        return b + 32'(im) * scale;
    endfunction

    function automatic logic [31:0] exp_res(logic [31:0] w, logic [31:0] a,
                                            logic [1:0] sz, logic sg);
        logic [31:0] r;
        logic [7:0]  b;
        logic [15:0] h;
        r = '0;
        if (sz == 2'b00) begin
            b = 8'((w >> (8 * a[1:0])) & 32'hff);
            r = {24'h0, b};
            if (sg && b[7]) r = r | 32'hffff_ff00;
        end else if (sz == 2'b01) begin
            h = a[1] ? w[31:16] : w[15:0];
            r = {16'h0, h};
            if (sg && h[15]) r = r | 32'hffff_0000;
        end else begin
            for (int k = 0; k < 4; k++) begin
                r[8*k +: 8] = w[8*((k + int'(a[1:0])) % 4) +: 8];
            end
        end
        return r;
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // One load: drive at negedge, check address, then result after next edge.
    task automatic do_load(logic [31:0] b, logic [31:0] r, logic [4:0] im, logic sel,
                           logic [1:0] sz, logic sg, logic [31:0] w, string req);
        logic [31:0] ea, er;
        ea = exp_addr(b, r, im, sel, sz);
        er = exp_res(w, ea, sz, sg);
        base_val = b; offs_reg_val = r; offs_imm = im; offs_sel = sel;
        acc_size = sz; sign_ext = sg; mem_rdata = w; req_valid = 1'b1;
        #1;
        check(mem_addr == (ea & 32'hffff_fffc), {req, " R5 addr"}, mem_addr, ea & 32'hffff_fffc);
        @(negedge clk);
        check(load_result == er, {req, " result"}, load_result, er);
        check(result_valid == 1'b1, "R9 valid", {31'h0, result_valid}, 32'h1);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        // R10: reset state
        check(load_result == '0, "R10 result", load_result, '0);
        check(result_valid == 1'b0, "R10 valid", {31'h0, result_valid}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R2/R3 immediate scaling, same immediate
        do_load(32'h1000, 32'h0, 5'd7, 1'b0, 2'b00, 1'b0, 32'h4433_2211, "R1");
        do_load(32'h1000, 32'h0, 5'd7, 1'b0, 2'b01, 1'b0, 32'h4433_2211, "R2");
        do_load(32'h1000, 32'h0, 5'd7, 1'b0, 2'b10, 1'b0, 32'h4433_2211, "R3");
        do_load(32'h1000, 32'h0, 5'd31, 1'b0, 2'b11, 1'b0, 32'h4433_2211, "R3 alt");
        // R4 register offset ignores immediate and scaling
        do_load(32'h2000, 32'h0000_0003, 5'd31, 1'b1, 2'b10, 1'b0, 32'hAABB_CCDD, "R4 word");
        do_load(32'h2000, 32'h0000_0005, 5'd9, 1'b1, 2'b01, 1'b0, 32'hAABB_CCDD, "R4 half");
        // R6 rotation for all low bits, sign ignored
        for (int a = 0; a < 4; a++) begin
            do_load(32'h3000 + 32'(a), 32'h0, 5'd0, 1'b0, 2'b10, 1'b1, 32'h8877_6655, "R6 rot");
        end
        // R7 all byte lanes, both extensions
        for (int a = 0; a < 4; a++) begin
            do_load(32'h4000 + 32'(a), 32'h0, 5'd0, 1'b0, 2'b00, 1'b1, 32'h80F1_7F02, "R7 sext");
            do_load(32'h4000 + 32'(a), 32'h0, 5'd0, 1'b0, 2'b00, 1'b0, 32'h80F1_7F02, "R7 zfill");
        end
        // R8 halfword lanes including odd addresses
        for (int a = 0; a < 4; a++) begin
            do_load(32'h5000 + 32'(a), 32'h0, 5'd0, 1'b0, 2'b01, 1'b1, 32'h8001_7FFE, "R8 sext");
            do_load(32'h5000 + 32'(a), 32'h0, 5'd0, 1'b0, 2'b01, 1'b0, 32'h8001_7FFE, "R8 zfill");
        end
        // R9 hold while idle
        begin
            logic [31:0] held;
            held = load_result;
            req_valid = 1'b0; mem_rdata = ~mem_rdata; base_val = 32'h7777_7771;
            @(negedge clk);
            check(load_result == held, "R9 hold", load_result, held);
            check(result_valid == 1'b0, "R9 idle valid", {31'h0, result_valid}, '0);
        end
        // random mix
        for (int n = 0; n < 400; n++) begin
            do_load($urandom, $urandom, 5'($urandom), 1'($urandom), 2'($urandom),
                    1'($urandom), $urandom, "R1 R2 R3 R4 R6 R7 R8 random");
        end
        req_valid = 1'b0;
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule